// File: doc/BRIEF.md
# Programmable-Width Byte CRC Engine

This block folds one 8-bit data frame into a running CRC in a single combinational evaluation. The generator polynomial and the starting value are plain inputs. The same logic can therefore run any generator of degree up to 32 without being rebuilt. The caller supplies the starting value, which is either a configured seed or the result for the previous byte. Passing each result back as the next seed chains the CRC across a message of any length.

The effective CRC width is 32, 16, 8 or 7 bits. A 2-bit width code picks the width. An internal decoder turns that code into a one-hot marker that sits on the CRC's most significant bit. An external marker may be selected in place of the decoded one. Data bits enter most significant first and are absorbed one per internal stage. The result holds only the low N bits of the selected width.

Top module: `crc_frame_engine`

## Requirements
- R1: With `mask_sel` low, `active_mask` is the decoded width code: code 2'b00 gives 32'h8000_0000, 2'b01 gives 32'h0000_8000, 2'b10 gives 32'h0000_0080 and 2'b11 gives 32'h0000_0040.
- R2: In 32-bit mode, `crc_next` equals a bit-serial MSB-first update of `seed` by `frame_data`. For each data bit, the feedback is bit 31 XOR the data bit, the state shifts left by one, and `poly` is XORed in when the feedback is 1.
- R3: In 16-bit mode, `crc_next` equals the same serial update with feedback taken from bit 15.
- R4: In 8-bit mode, `crc_next` equals the same serial update with feedback taken from bit 7.
- R5: In 7-bit mode, `crc_next` equals the same serial update with feedback taken from bit 6.
- R6: Every bit of `crc_next` above the marker position is zero.
- R7: Chaining the bytes of the ASCII string "123456789" (0x31 through 0x39) gives the following results. With seed 32'hFFFF_FFFF and poly 32'h04C1_1DB7 in 32-bit mode the result is 32'h0376_E6E7. With seed 16'hFFFF and poly 16'h1021 in 16-bit mode it is 16'h29B1. With seed 0 and poly 8'h07 in 8-bit mode it is 8'hF4. With seed 0 and poly 7'h09 in 7-bit mode it is 7'h75.
- R8: With `mask_sel` high, `active_mask` equals `mask_ext`, and the update uses that marker instead of the width code.
- R9: An all-zero frame with an all-zero seed yields an all-zero result for any polynomial and width.
- R10: Seed bits above the marker position have no effect on `crc_next`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| frame_data | input | 8 | Data frame, most significant bit absorbed first |
| seed | input | 32 | Starting CRC value (configured seed or previous result) |
| poly | input | 32 | Generator coefficients without the implicit top term |
| width_code | input | 2 | Width select: 00=32, 01=16, 10=8, 11=7 bits |
| mask_sel | input | 1 | High selects `mask_ext` as the top-bit marker |
| mask_ext | input | 32 | External one-hot top-bit marker |
| active_mask | output | 32 | Marker in use for this evaluation |
| crc_next | output | 32 | Updated CRC, zero above the selected width |

## Verification
The checks assume that whenever `mask_sel` is high, `mask_ext` carries exactly one set bit. With a zero or multi-bit marker the trimming and feedback have no defined meaning. They also assume that the polynomial has no bits at or above the marker position. The stimulus therefore drives only the four legal marker positions through `mask_ext`, and it clips every random polynomial to the width under test. Seeds, by contrast, are left unclipped on purpose, so that R10 is exercised by the random traffic.

// File: rtl/crc_frame_pkg.sv
package crc_frame_pkg;

    localparam int CRC_W  = 32;
    localparam int DATA_W = 8;

    typedef logic [CRC_W-1:0]  crc_word_t;
    typedef logic [DATA_W-1:0] frame_t;

    typedef enum logic [1:0] {
        WIDTH_32 = 2'b00,
        WIDTH_16 = 2'b01,
        WIDTH_8  = 2'b10,
        WIDTH_7  = 2'b11
    } width_code_e;

    typedef struct packed {
        crc_word_t state;
        logic      feedback;
    } step_t;

    localparam int TOP_32 = 31;
    localparam int TOP_16 = 15;
    localparam int TOP_8  = 7;
    localparam int TOP_7  = 6;

    function automatic crc_word_t marker_for(input width_code_e code);
        crc_word_t m;
        m = '0;
        unique case (code)
            WIDTH_32: m[TOP_32] = 1'b1;
            WIDTH_16: m[TOP_16] = 1'b1;
            WIDTH_8:  m[TOP_8]  = 1'b1;
            WIDTH_7:  m[TOP_7]  = 1'b1;
            default:  m = '0;
        endcase
        return m;
    endfunction

    function automatic crc_word_t keep_for(input crc_word_t marker);
        return marker | (marker - crc_word_t'(1));
    endfunction

endpackage

// File: rtl/crc_width_decoder.sv
module crc_width_decoder
    import crc_frame_pkg::*;
#(
    parameter int CRC_W = crc_frame_pkg::CRC_W
) (
    input  logic [1:0]       width_code,
    input  logic             mask_sel,
    input  logic [CRC_W-1:0] mask_ext,
    output logic [CRC_W-1:0] marker
);
    logic [CRC_W-1:0] decoded;

    always_comb begin
        decoded = CRC_W'(marker_for(width_code_e'(width_code)));
        marker  = mask_sel ? mask_ext : decoded;
    end
endmodule

// File: rtl/crc_bit_step.sv
module crc_bit_step
    import crc_frame_pkg::*;
#(
    parameter int CRC_W = crc_frame_pkg::CRC_W
) (
    input  logic [CRC_W-1:0] state_in,
    input  logic [CRC_W-1:0] poly,
    input  logic [CRC_W-1:0] marker,
    input  logic             din,
    output logic [CRC_W-1:0] state_out
);
    logic             fb;
    logic [CRC_W-1:0] shifted;

    always_comb begin
        fb        = (|(state_in & marker)) ^ din;
        shifted   = {state_in[CRC_W-2:0], 1'b0};
        state_out = fb ? (shifted ^ poly) : shifted;
    end
endmodule

// File: rtl/crc_result_trim.sv
module crc_result_trim
    import crc_frame_pkg::*;
#(
    parameter int CRC_W = crc_frame_pkg::CRC_W
) (
    input  logic [CRC_W-1:0] raw,
    input  logic [CRC_W-1:0] marker,
    output logic [CRC_W-1:0] trimmed
);
    logic [CRC_W-1:0] keep;

    always_comb begin
        keep    = marker | (marker - CRC_W'(1));
        trimmed = raw & keep;
    end
endmodule

// File: rtl/crc_frame_engine.sv
module crc_frame_engine
    import crc_frame_pkg::*;
#(
    parameter int CRC_W  = crc_frame_pkg::CRC_W,
    parameter int DATA_W = crc_frame_pkg::DATA_W
) (
    input  logic [DATA_W-1:0] frame_data,
    input  logic [CRC_W-1:0]  seed,
    input  logic [CRC_W-1:0]  poly,
    input  logic [1:0]        width_code,
    input  logic              mask_sel,
    input  logic [CRC_W-1:0]  mask_ext,
    output logic [CRC_W-1:0]  active_mask,
    output logic [CRC_W-1:0]  crc_next
);
    localparam int STAGES = DATA_W;

    logic [CRC_W-1:0] marker;
    logic [CRC_W-1:0] chain [STAGES+1];

    crc_width_decoder #(.CRC_W(CRC_W)) u_decode (
        .width_code (width_code),
        .mask_sel   (mask_sel),
        .mask_ext   (mask_ext),
        .marker     (marker)
    );

    assign chain[0] = seed;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            crc_bit_step #(.CRC_W(CRC_W)) u_step (
                .state_in  (chain[k]),
                .poly      (poly),
                .marker    (marker),
                .din       (frame_data[STAGES-1-k]),
                .state_out (chain[k+1])
            );
        end
    endgenerate

    crc_result_trim #(.CRC_W(CRC_W)) u_trim (
        .raw     (chain[STAGES]),
        .marker  (marker),
        .trimmed (crc_next)
    );

    assign active_mask = marker;
endmodule

// File: rtl/crc_frame_engine_chk.sv
module crc_frame_engine_chk #(
    parameter int CRC_W  = 32,
    parameter int DATA_W = 8
) (
    input logic [DATA_W-1:0] frame_data,
    input logic [CRC_W-1:0]  seed,
    input logic [1:0]        width_code,
    input logic              mask_sel,
    input logic [CRC_W-1:0]  mask_ext,
    input logic [CRC_W-1:0]  active_mask,
    input logic [CRC_W-1:0]  crc_next
);
    logic [CRC_W-1:0] above;

    always_comb begin
        above = ~(active_mask | (active_mask - CRC_W'(1)));
        if (!mask_sel) begin
            // R1
            mask_onehot_chk: assert ($onehot(active_mask));
            // R1
            code32_chk: assert (width_code != 2'b00 || active_mask[CRC_W-1]);
        end
        if (mask_sel) begin
            // R8
            override_chk: assert (active_mask == mask_ext);
        end
        if ($onehot(active_mask)) begin
            // R6
            upper_zero_chk: assert ((crc_next & above) == '0);
        end
        if (frame_data == '0 && seed == '0) begin
            // R9
            zero_in_chk: assert (crc_next == '0);
        end
    end
endmodule

bind crc_frame_engine crc_frame_engine_chk #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_chk (
    .frame_data  (frame_data),
    .seed        (seed),
    .width_code  (width_code),
    .mask_sel    (mask_sel),
    .mask_ext    (mask_ext),
    .active_mask (active_mask),
    .crc_next    (crc_next)
);

// File: tb/crc_frame_engine_bench.sv
module crc_frame_engine_bench;

    typedef struct {
        logic [31:0] exp_crc;
        logic [31:0] exp_mask;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  frame_data = '0;
    logic [31:0] seed = '0;
    logic [31:0] poly = '0;
    logic [1:0]  width_code = '0;
    logic        mask_sel = 1'b0;
    logic [31:0] mask_ext = '0;
    logic [31:0] active_mask;
    logic [31:0] crc_next;

    int total = 0;
    int bad = 0;
    item_t q[$];

    always #10 clk = ~clk;

    crc_frame_engine u_crc_frame_engine (
        .frame_data  (frame_data),
        .seed        (seed),
        .poly        (poly),
        .width_code  (width_code),
        .mask_sel    (mask_sel),
        .mask_ext    (mask_ext),
        .active_mask (active_mask),
        .crc_next    (crc_next)
    );

    function automatic int width_of(input logic [1:0] c);
        case (c)
            2'b00:   return 32;
            2'b01:   return 16;
            2'b10:   return 8;
            default: return 7;
        endcase
    endfunction

    function automatic logic [31:0] mask_of(input int w);
        return 32'h1 << (w - 1);
    endfunction

    function automatic logic [31:0] low_bits(input int w);
        return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    endfunction

    function automatic logic [31:0] serial_ref(input logic [7:0] d, input logic [31:0] s0,
                                               input logic [31:0] p, input int w);
        logic [31:0] s;
        logic fb;
        s = s0;
        for (int i = 7; i >= 0; i--) begin
            fb = s[w-1] ^ d[i];
            s = s << 1;
            if (fb) s = s ^ p;
        end
        return s & low_bits(w);
    endfunction

    task automatic drive(input logic [7:0] d, input logic [31:0] s, input logic [31:0] p,
                         input logic [1:0] code, input logic sel, input logic [31:0] ext,
                         input string tag);
        item_t it;
        int w;
        @(posedge clk);
        #1;
        frame_data = d; seed = s; poly = p; width_code = code;
        mask_sel = sel; mask_ext = ext;
        w = sel ? ($clog2(ext) + 1) : width_of(code);
        it.exp_crc = serial_ref(d, s, p, w);
        it.exp_mask = sel ? ext : mask_of(w);
        it.tag = tag;
        q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if (crc_next !== it.exp_crc || active_mask !== it.exp_mask) begin
                bad++;
                $display("FAIL %s: crc=%h mask=%h expected crc=%h mask=%h",
                         it.tag, crc_next, active_mask, it.exp_crc, it.exp_mask);
            end
        end
    end

    task automatic run_chain(input logic [31:0] s0, input logic [31:0] p,
                             input logic [1:0] code, input logic [31:0] expv, input string tag);
        logic [31:0] s;
        s = s0;
        for (int i = 0; i < 9; i++) begin
            @(posedge clk);
            #1;
            frame_data = 8'h31 + 8'(i); seed = s; poly = p;
            width_code = code; mask_sel = 1'b0; mask_ext = '0;
            @(negedge clk);
            s = crc_next;
        end
        total++;
        if (s !== expv) begin
            bad++;
            $display("FAIL %s: chained result=%h expected=%h", tag, s, expv);
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // Reset state: all-zero inputs give zero result (R9), decoded 32-bit marker (R1)
        drive(8'h00, 32'h0, 32'h04C11DB7, 2'b00, 1'b0, 32'h0, "R9 zero");
        // R1 decode of every code
        drive(8'hA5, 32'h1234_5678, 32'h04C11DB7, 2'b00, 1'b0, 32'h0, "R1 code00");
        drive(8'hA5, 32'h1234_5678, 32'h0000_1021, 2'b01, 1'b0, 32'h0, "R1 code01");
        drive(8'hA5, 32'h1234_5678, 32'h0000_0007, 2'b10, 1'b0, 32'h0, "R1 code10");
        drive(8'hA5, 32'h1234_5678, 32'h0000_0009, 2'b11, 1'b0, 32'h0, "R1 code11");
        // R9 with other polynomials and widths
        drive(8'h00, 32'h0, 32'hDEAD_BEEF, 2'b01, 1'b0, 32'h0, "R9 zero 16");
        drive(8'h00, 32'h0, 32'h0000_0031, 2'b10, 1'b0, 32'h0, "R9 zero 8");
        // R10 upper seed bits
        drive(8'h3C, 32'h0000_ABCD, 32'h0000_8005, 2'b01, 1'b0, 32'h0, "R10 low seed");
        drive(8'h3C, 32'hFFFF_ABCD, 32'h0000_8005, 2'b01, 1'b0, 32'h0, "R10 high seed");
        drive(8'hF0, 32'h5A5A_5A2B, 32'h0000_0009, 2'b11, 1'b0, 32'h0, "R10 7-bit upper seed");
        // R8 external marker overriding the code
        drive(8'h96, 32'h0000_FFFF, 32'h0000_1021, 2'b00, 1'b1, 32'h0000_8000, "R8 ext16");
        drive(8'h96, 32'h0000_00FF, 32'h0000_0007, 2'b01, 1'b1, 32'h0000_0080, "R8 ext8");
        drive(8'h96, 32'hFFFF_FFFF, 32'h04C11DB7, 2'b11, 1'b1, 32'h8000_0000, "R8 ext32");
        // Boundary frames
        drive(8'hFF, 32'hFFFF_FFFF, 32'h04C11DB7, 2'b00, 1'b0, 32'h0, "R2 all ones");
        drive(8'h80, 32'h0, 32'h0000_0009, 2'b11, 1'b0, 32'h0, "R5 single msb");
        drive(8'h01, 32'h0000_0040, 32'h0000_0009, 2'b11, 1'b0, 32'h0, "R5 top seed");

        // Random traffic, R2..R6
        for (int n = 0; n < 400; n++) begin
            logic [1:0] c;
            int w;
            c = 2'(n % 4);
            w = width_of(c);
            r = $urandom();
            case (c)
                2'b00: drive(8'($urandom()), r, 32'($urandom()), c, 1'b0, 32'h0, "R2 rand32");
                2'b01: drive(8'($urandom()), r, 32'($urandom()) & low_bits(w), c, 1'b0, 32'h0, "R3 rand16");
                2'b10: drive(8'($urandom()), r, 32'($urandom()) & low_bits(w), c, 1'b0, 32'h0, "R4 rand8 R6");
                default: drive(8'($urandom()), r, 32'($urandom()) & low_bits(w), c, 1'b0, 32'h0, "R5 rand7 R6");
            endcase
        end
        repeat (3) @(posedge clk);

        // R7 chained check values
        run_chain(32'hFFFF_FFFF, 32'h04C11DB7, 2'b00, 32'h0376_E6E7, "R7 crc32");
        run_chain(32'h0000_FFFF, 32'h0000_1021, 2'b01, 32'h0000_29B1, "R7 crc16");
        run_chain(32'h0, 32'h0000_0007, 2'b10, 32'h0000_00F4, "R7 crc8");
        run_chain(32'h0, 32'h0000_0009, 2'b11, 32'h0000_0075, "R7 crc7");

        repeat (2) @(posedge clk);
        if (q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard: pending=%0d expected=0", q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule